// File: doc/BRIEF.md
# Function Block Input/Output Router

This block is the routing shell that sits around one configurable digital function block (timer, counter, dead-band generator, CRC/PRS engine, SPI master, SPI slave, serial transmitter or serial receiver). Two 8-bit configuration registers set it up through a simple write/read port.

The input register picks the core's data and clock from two groups of sixteen candidate row signals. The output register does three jobs. It places the core's primary and auxiliary outputs onto one of four row lines each. It can route those outputs through a two-flop resynchronizer. In SPI-slave mode it is read differently, and sources the slave-select input either from an auxiliary candidate or directly from a register bit.

The core itself is outside this block. It appears here only as a 3-bit function code, a PRS/CRC choice flag and its two output signals. The router also applies the exceptions that depend on the function. Dead-band mode takes its reference from the previous block's primary output. PRS and transmitter modes force the data input low. SPI-slave mode never drives the auxiliary row lines.

Top module: `blk_io_router`

## Requirements
- R1: After reset both configuration registers read 0x00, and no primary or auxiliary row enable is high.
- R2: A write with `cfg_sel`=0 loads the input register and a write with `cfg_sel`=1 loads the output register, effective from the next clock. `cfg_rdata` shows the selected register, and bit 2 of the output register always reads 0.
- R3: `core_data` equals `data_cand[in_reg[7:4]]` and `core_clk` equals `clk_cand[in_reg[3:0]]`, except as stated in R4.
- R4: Function codes are 0 timer, 1 counter, 2 dead-band, 3 CRC/PRS, 4 SPI master, 5 SPI slave, 6 transmitter, 7 receiver. With code 3 and `prs_sel`=1, and also with code 6, `core_data` is 0. With code 3 and `prs_sel`=0, the selected serial stream passes through.
- R5: When output-register bit 3 (output enable) is 1, `row_oe` is one-hot at the line chosen by bits 1:0, and that `row_out` line carries the primary output. When bit 3 is 0, `row_oe` is all zero. Lines that are not driven read 0 on `row_out`.
- R6: In any mode other than SPI slave, when bit 6 (auxiliary enable) is 1, `aux_row_oe` is one-hot at the line chosen by bits 5:4 and carries `core_aux`. When bit 6 is 0, `aux_row_oe` is all zero.
- R7: In SPI-slave mode `aux_row_oe` is always zero, whatever the value of bits 6:4.
- R8: In SPI-slave mode with bit 6 = 0, `core_aux_in` (slave select) equals `aux_cand[bits 5:4]`.
- R9: In SPI-slave mode with bit 6 = 1, `core_aux_in` equals bit 4 of the output register.
- R10: In dead-band mode `core_aux_in` equals `prev_primary`, regardless of bits 6:4.
- R11: In every mode other than dead-band and SPI slave, `core_aux_in` is 0.
- R12: With bit 7 (resync) at 1, the values on the row lines follow the core outputs two clocks late. With bit 7 at 0, they follow in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 input register, 1 output register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| func_mode | input | 3 | Function code of the core |
| prs_sel | input | 1 | In code 3: 1 = PRS, 0 = CRC |
| data_cand | input | 16 | Candidate data sources |
| clk_cand | input | 16 | Candidate clock sources |
| aux_cand | input | 4 | Candidate auxiliary (slave-select) sources |
| prev_primary | input | 1 | Primary output of the previous block |
| core_primary | input | 1 | Core primary output |
| core_aux | input | 1 | Core auxiliary output |
| core_data | output | 1 | Data input to the core |
| core_clk | output | 1 | Clock input to the core |
| core_aux_in | output | 1 | Auxiliary input to the core (reference or slave select) |
| row_out | output | 4 | Primary row line values |
| row_oe | output | 4 | Primary row line enables |
| aux_row_out | output | 4 | Auxiliary row line values |
| aux_row_oe | output | 4 | Auxiliary row line enables |

## Verification
Configuration writes take effect one clock after the write edge. The input selection, the mode exceptions and the row enables then follow combinationally. Row values are due in the same cycle without resync and two clocks later with it. Each random trial writes both registers and then sets the inputs. It waits two full clocks before sampling at the falling edge, so every result has settled under either resync setting. A directed case changes the primary output under resync and samples after one clock, where the old value is expected, and after the second clock, where the new value is expected.

// File: rtl/blk_io_pkg.sv
package blk_io_pkg;
  typedef enum logic [2:0] {
    FM_TIMER = 3'd0, FM_COUNT = 3'd1, FM_DBAND = 3'd2, FM_CRCPRS = 3'd3,
    FM_SPIM  = 3'd4, FM_SPIS  = 3'd5, FM_TX    = 3'd6, FM_RX     = 3'd7
  } fmode_e;

  // n-way pick of one candidate bit
  function automatic logic pick16(input logic [15:0] cand, input logic [3:0] idx);
    return cand[idx];
  endfunction

  function automatic logic pick4(input logic [3:0] cand, input logic [1:0] idx);
    return cand[idx];
  endfunction

  // slave-select source in SPI-slave mode
  function automatic logic ss_value(input logic aux_en, input logic [1:0] aux_sel,
                                    input logic [3:0] aux_cand);
    return aux_en ? aux_sel[0] : aux_cand[aux_sel];
  endfunction
endpackage

// File: rtl/blk_io_cfg_regs.sv
module blk_io_cfg_regs #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [3:0]       dsel,
  output logic [3:0]       csel,
  output logic             resync,
  output logic             aux_en,
  output logic [1:0]       aux_sel,
  output logic             oe,
  output logic [1:0]       osel
);
  localparam int RSV_BIT = 2;
  logic [REG_W-1:0] in_q;
  logic [REG_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) begin
        out_q          <= cfg_wdata;
        out_q[RSV_BIT] <= 1'b0;
      end else begin
        in_q <= cfg_wdata;
      end
    end
  end

  assign cfg_rdata = cfg_sel ? out_q : in_q;
  assign dsel      = in_q[7:4];
  assign csel      = in_q[3:0];
  assign resync    = out_q[7];
  assign aux_en    = out_q[6];
  assign aux_sel   = out_q[5:4];
  assign oe        = out_q[3];
  assign osel      = out_q[1:0];

  AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> cfg_rdata[RSV_BIT] == 1'b0); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> in_q == $past(cfg_wdata)); // R2
endmodule

// File: rtl/blk_io_in_mux.sv
module blk_io_in_mux
  import blk_io_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int AUX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fmode_e               mode,
  input  logic                 prs_sel,
  input  logic [SEL_W-1:0]     dsel,
  input  logic [SEL_W-1:0]     csel,
  input  logic [(1<<SEL_W)-1:0] data_cand,
  input  logic [(1<<SEL_W)-1:0] clk_cand,
  input  logic [(1<<AUX_W)-1:0] aux_cand,
  input  logic                 prev_primary,
  input  logic                 aux_en,
  input  logic [AUX_W-1:0]     aux_sel,
  output logic                 core_data,
  output logic                 core_clk,
  output logic                 core_aux_in
);
  logic data_sel;
  logic force_low;

  assign data_sel  = pick16(data_cand, dsel);
  assign force_low = (mode == FM_TX) || (mode == FM_CRCPRS && prs_sel);
  assign core_data = force_low ? 1'b0 : data_sel;
  assign core_clk  = pick16(clk_cand, csel);

  always_comb begin
    unique case (mode)
      FM_DBAND: core_aux_in = prev_primary;
      FM_SPIS:  core_aux_in = ss_value(aux_en, aux_sel, aux_cand);
      default:  core_aux_in = 1'b0;
    endcase
  end

  AST_DBAND_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mode == FM_DBAND |-> core_aux_in == prev_primary); // R10
  AST_SS_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_SPIS && aux_en) |-> core_aux_in == aux_sel[0]); // R9
  AST_PRS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_CRCPRS && prs_sel) |-> !core_data); // R4
endmodule

// File: rtl/blk_io_out_steer.sv
module blk_io_out_steer
  import blk_io_pkg::*;
#(
  parameter int ROW_SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  fmode_e                   mode,
  input  logic                     resync,
  input  logic                     oe,
  input  logic [ROW_SEL_W-1:0]     osel,
  input  logic                     aux_en,
  input  logic [ROW_SEL_W-1:0]     aux_sel,
  input  logic                     core_primary,
  input  logic                     core_aux,
  output logic [(1<<ROW_SEL_W)-1:0] row_out,
  output logic [(1<<ROW_SEL_W)-1:0] row_oe,
  output logic [(1<<ROW_SEL_W)-1:0] aux_row_out,
  output logic [(1<<ROW_SEL_W)-1:0] aux_row_oe
);
  localparam int ROWS = 1 << ROW_SEL_W;

  logic [1:0] sync1, sync2;
  logic       prim_v, aux_v;
  logic       aux_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {core_primary, core_aux};
      sync2 <= sync1;
    end
  end

  assign prim_v    = resync ? sync2[1] : core_primary;
  assign aux_v     = resync ? sync2[0] : core_aux;
  assign aux_drive = aux_en && (mode != FM_SPIS);

  for (genvar g = 0; g < ROWS; g++) begin : g_line
    assign row_oe[g]      = oe && (osel == ROW_SEL_W'(g));
    assign row_out[g]     = row_oe[g] && prim_v;
    assign aux_row_oe[g]  = aux_drive && (aux_sel == ROW_SEL_W'(g));
    assign aux_row_out[g] = aux_row_oe[g] && aux_v;
  end

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_oe) && (oe || row_oe == '0)); // R5
  AST_SPIS_NO_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    mode == FM_SPIS |-> aux_row_oe == '0); // R7
  AST_AUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(aux_row_oe) <= 1); // R6
endmodule

// File: rtl/blk_io_router.sv
module blk_io_router
  import blk_io_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int ROW_SEL_W = 2,
  parameter int REG_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_sel,
  input  logic [REG_W-1:0]          cfg_wdata,
  output logic [REG_W-1:0]          cfg_rdata,
  input  logic [2:0]                func_mode,
  input  logic                      prs_sel,
  input  logic [(1<<SEL_W)-1:0]     data_cand,
  input  logic [(1<<SEL_W)-1:0]     clk_cand,
  input  logic [(1<<ROW_SEL_W)-1:0] aux_cand,
  input  logic                      prev_primary,
  input  logic                      core_primary,
  input  logic                      core_aux,
  output logic                      core_data,
  output logic                      core_clk,
  output logic                      core_aux_in,
  output logic [(1<<ROW_SEL_W)-1:0] row_out,
  output logic [(1<<ROW_SEL_W)-1:0] row_oe,
  output logic [(1<<ROW_SEL_W)-1:0] aux_row_out,
  output logic [(1<<ROW_SEL_W)-1:0] aux_row_oe
);
  fmode_e     mode;
  logic [3:0] dsel, csel;
  logic       resync, aux_en, oe;
  logic [1:0] aux_sel, osel;

  assign mode = fmode_e'(func_mode);

  blk_io_cfg_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dsel(dsel), .csel(csel),
    .resync(resync), .aux_en(aux_en), .aux_sel(aux_sel), .oe(oe), .osel(osel)
  );

  blk_io_in_mux #(.SEL_W(SEL_W), .AUX_W(ROW_SEL_W)) u_in (
    .clk(clk), .rst_n(rst_n), .mode(mode), .prs_sel(prs_sel),
    .dsel(dsel), .csel(csel), .data_cand(data_cand), .clk_cand(clk_cand),
    .aux_cand(aux_cand), .prev_primary(prev_primary), .aux_en(aux_en),
    .aux_sel(aux_sel), .core_data(core_data), .core_clk(core_clk),
    .core_aux_in(core_aux_in)
  );

  blk_io_out_steer #(.ROW_SEL_W(ROW_SEL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .resync(resync), .oe(oe),
    .osel(osel), .aux_en(aux_en), .aux_sel(aux_sel),
    .core_primary(core_primary), .core_aux(core_aux),
    .row_out(row_out), .row_oe(row_oe),
    .aux_row_out(aux_row_out), .aux_row_oe(aux_row_oe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (row_oe == '0 && aux_row_oe == '0)); // R1
endmodule

// File: tb/blk_io_router_bench.sv
module blk_io_router_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [2:0] func_mode = 0;
  logic prs_sel = 0, prev_primary = 0, core_primary = 0, core_aux = 0;
  logic [15:0] data_cand = 0, clk_cand = 0;
  logic [3:0] aux_cand = 0;
  logic core_data, core_clk, core_aux_in;
  logic [3:0] row_out, row_oe, aux_row_out, aux_row_oe;
  int checks = 0, errors = 0;
  logic [7:0] m_in, m_out;

  always #10 clk = ~clk;

  blk_io_router u_blk_io_router (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel) m_out = {d[7:3], 1'b0, d[1:0]}; else m_in = d;
  endtask

  function automatic logic e_data(input logic [2:0] m, input logic p);
    if (m == 3'd6 || (m == 3'd3 && p)) return 1'b0;
    return data_cand[m_in[7:4]];
  endfunction
  function automatic logic e_aux_in(input logic [2:0] m);
    case (m)
      3'd2: return prev_primary;
      3'd5: return m_out[6] ? m_out[4] : aux_cand[m_out[5:4]];
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic [3:0] e_oe();
    return m_out[3] ? (4'b1 << m_out[1:0]) : 4'b0;
  endfunction
  function automatic logic [3:0] e_aux_oe(input logic [2:0] m);
    return (m_out[6] && m != 3'd5) ? (4'b1 << m_out[5:4]) : 4'b0;
  endfunction

  task automatic check_all();
    chk("R3 clk", core_clk, clk_cand[m_in[3:0]]);
    chk("R3/R4 data", core_data, e_data(func_mode, prs_sel));
    chk("R8/R9/R10/R11 aux_in", core_aux_in, e_aux_in(func_mode));
    chk("R5 row_oe", row_oe, e_oe());
    chk("R5 row_out", row_out, e_oe() & {4{core_primary}});
    chk("R6/R7 aux_row_oe", aux_row_oe, e_aux_oe(func_mode));
    chk("R6 aux_row_out", aux_row_out, e_aux_oe(func_mode) & {4{core_aux}});
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_in = 0; m_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cfg_sel = 0; #1 chk("R1 in reg", cfg_rdata, 8'h00);
    cfg_sel = 1; #1 chk("R1 out reg", cfg_rdata, 8'h00);
    chk("R1 oe", {row_oe, aux_row_oe}, 8'h00);

    // R2 reserved bit
    wr(1, 8'hFF); cfg_sel = 1; #1 chk("R2 out read", cfg_rdata, 8'hFB);
    wr(0, 8'hA5); cfg_sel = 0; #1 chk("R2 in read", cfg_rdata, 8'hA5);

    // R7 SPIS with aux enable set: no aux drive, R9 soft ss
    func_mode = 3'd5; wr(1, 8'h58);
    @(negedge clk); chk("R7 spis aux off", aux_row_oe, 8'h0);
    chk("R9 ss=bit4", core_aux_in, 1'b1);
    // R8 ss from candidate 2
    wr(1, 8'h20); aux_cand = 4'b0100; @(negedge clk);
    chk("R8 ss cand", core_aux_in, 1'b1);
    aux_cand = 4'b1011; #1 chk("R8 ss cand low", core_aux_in, 1'b0);

    // R10 dead-band ignores aux bits
    func_mode = 3'd2; wr(1, 8'h70); prev_primary = 1; #1
    chk("R10 ref", core_aux_in, 1'b1);
    prev_primary = 0; #1 chk("R10 ref low", core_aux_in, 1'b0);

    // R4 PRS and CRC
    wr(0, 8'h30); data_cand = 16'h0008; func_mode = 3'd3; prs_sel = 1; #1
    chk("R4 prs low", core_data, 1'b0);
    prs_sel = 0; #1 chk("R4 crc pass", core_data, 1'b1);
    func_mode = 3'd6; #1 chk("R4 tx low", core_data, 1'b0);

    // R12 resync latency
    func_mode = 3'd0; core_primary = 0; wr(1, 8'h8A);
    @(negedge clk); @(negedge clk);
    chk("R12 settled", row_out, 4'b0000);
    core_primary = 1;
    @(negedge clk); chk("R12 one clock", row_out, 4'b0000);
    @(negedge clk); chk("R12 two clocks", row_out, 4'b0100);
    wr(1, 8'h0A); core_primary = 0; #1 chk("R12 direct", row_out, 4'b0000);
    core_primary = 1; #1 chk("R12 direct hi", row_out, 4'b0100);

    // random trials
    for (int i = 0; i < 300; i++) begin
      wr(0, 8'($urandom));
      wr(1, 8'($urandom));
      @(negedge clk);
      func_mode = 3'($urandom); prs_sel = 1'($urandom);
      data_cand = 16'($urandom); clk_cand = 16'($urandom);
      aux_cand = 4'($urandom); prev_primary = 1'($urandom);
      core_primary = 1'($urandom); core_aux = 1'($urandom);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check_all();
      cfg_sel = 1'($urandom); #1
      chk("R2 readback", cfg_rdata, cfg_sel ? m_out : m_in);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule